// File: doc/BRIEF.md
# Indirectly Addressed Vectored Interrupt Controller

This block collects up to 128 interrupt sources and presents them to a processor as a single interrupt request line with a vector. Software reaches the per-source settings through one select register. It first writes a source index there. Mode, vector, enable, disable, clear and set operations then act on that one source only. Each source has a 3-bit priority and a trigger type: level or edge, with either polarity. A software set command can also force a source pending.

Among the sources that are both enabled and pending, the block picks the one with the highest priority. A priority tie goes to the lower index. The request line rises only when this winner's priority is strictly above the priority now in service. Reading the vector register acknowledges the winner and returns its vector. The read also pushes the winner's level onto an eight-entry nesting stack and clears any latched pending state of that source. If no source qualifies when the vector is read, the read returns the spurious vector and pushes a placeholder entry. Software must still balance that entry with an end-of-interrupt write.

Nesting is tracked by a small state machine with three states. NS_EMPTY means no service is active. NS_NESTED means one to seven levels are active. NS_FULL means all eight levels are in use. The transitions are named as follows. Push moves NS_EMPTY to NS_NESTED. Push at depth seven moves NS_NESTED to NS_FULL. Pop at depth one moves NS_NESTED back to NS_EMPTY. Pop moves NS_FULL to NS_NESTED. All other push and pop events keep the current state. A push while in NS_FULL is dropped, and a pop while in NS_EMPTY is ignored.

Top module: `intc_vectored`

## Requirements
- R1: The select register at byte offset 0x00 holds a 7-bit source index in bits 6:0 and reads back the value written. Upper write bits are dropped.
- R2: The mode register (0x04) and vector register (0x08) read and write the stored 6-bit mode and 32-bit vector of the currently selected source. In the mode field, bits 2:0 are the priority (7 highest), bit 4 selects edge (1) or level (0), and bit 5 selects active-low/falling (1) or active-high/rising (0).
- R3: Any write to 0x40 enables the selected source, and any write to 0x44 disables it. The status register at 0x30 reads bit 0 as the enable of the selected source and bit 1 as its pending state.
- R4: A write to 0x4C forces the selected source pending. A write to 0x48 clears its latched pending state.
- R5: irq_req is high exactly when an enabled pending source exists whose priority is strictly greater than the priority at the top of the nesting stack, or when such a source exists and the stack is empty. Ties between sources go to the lower index.
- R6: Reading 0x10 returns the winning source's vector one cycle after the read and pushes that source's level. Reading 0x18 afterwards returns the index of the source in service.
- R7: Reading 0x10 with no qualifying source returns the spurious vector register (0x3C). The current-source register then reads 0. The read still pushes an entry that a write to 0x38 must remove.
- R8: The nesting stack holds eight levels. Each write to 0x38 pops one level. After eight pops the stack is empty and sources of any priority can again raise irq_req. A vector read with eight levels active returns the spurious vector and pushes nothing.
- R9: An edge-mode source latches pending on its active edge, stays pending after the input returns, and is cleared by the vector read that acknowledges it. A level-mode source is pending only while its input is at the active level.
- R10: After reset every source is disabled, not pending, with mode 0 and vector 0. The select register, the spurious vector and the stack are cleared, and irq_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
Register state and the read data register are updated on the clock edge that samples the strobe. bus_rdata therefore carries a read result one cycle after bus_rd, and the bench samples it on the following falling edge. irq_req is combinational from the stored state and the inputs. It reflects a register write, a vector read, an end-of-interrupt or an input change by the first falling edge after the edge that took the operation, or at once for an input change. Each check is placed on that falling edge, away from the active edge. Expected vectors, indices and priorities are computed arithmetically from the source index in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int IDX_W  = 7;
    localparam int PRIO_W = 3;
    localparam int MODE_W = 6;
    localparam int LVL_W  = PRIO_W + 1;

    localparam logic [7:0] A_SEL   = 8'h00;
    localparam logic [7:0] A_MODE  = 8'h04;
    localparam logic [7:0] A_VEC   = 8'h08;
    localparam logic [7:0] A_VREAD = 8'h10;
    localparam logic [7:0] A_CUR   = 8'h18;
    localparam logic [7:0] A_STAT  = 8'h30;
    localparam logic [7:0] A_EOI   = 8'h38;
    localparam logic [7:0] A_SPUR  = 8'h3C;
    localparam logic [7:0] A_EN    = 8'h40;
    localparam logic [7:0] A_DIS   = 8'h44;
    localparam logic [7:0] A_CLR   = 8'h48;
    localparam logic [7:0] A_SET   = 8'h4C;

    typedef enum logic [1:0] {
        NS_EMPTY  = 2'd0,
        NS_NESTED = 2'd1,
        NS_FULL   = 2'd2
    } nest_state_t;

    // thresh: 0 = no level in service, otherwise priority + 1
    typedef struct packed {
        logic             real_src;
        logic [IDX_W-1:0] src;
        logic [LVL_W-1:0] thresh;
    } nest_entry_t;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_in,
    input  logic [IDX_W-1:0]          sel,
    input  logic                      mode_we,
    input  logic                      vec_we,
    input  logic [31:0]               wdata,
    input  logic                      en_set,
    input  logic                      en_clr,
    input  logic                      pend_set,
    input  logic                      pend_clr,
    input  logic                      ack,
    input  logic [IDX_W-1:0]          ack_idx,
    output logic [MODE_W-1:0]         sel_mode,
    output logic [31:0]               sel_vec,
    output logic                      sel_en,
    output logic                      sel_pend,
    output logic [31:0]               ack_vec,
    output logic [NUM_SRC-1:0]        req,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
    logic [MODE_W-1:0] mode_arr [NUM_SRC];
    logic [31:0]       vec_arr  [NUM_SRC];
    logic [NUM_SRC-1:0] en_v, pend_v;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [MODE_W-1:0] mode_q;
        logic [31:0]       vec_q;
        logic              en_q, pstore_q, prev_q, active, hit;

        assign hit    = (sel == IDX_W'(i));
        assign active = src_in[i] ^ mode_q[5];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q   <= '0;
                vec_q    <= '0;
                en_q     <= 1'b0;
                pstore_q <= 1'b0;
                prev_q   <= 1'b0;
            end else begin
                prev_q <= active;
                if (hit && mode_we) mode_q <= wdata[MODE_W-1:0];
                if (hit && vec_we)  vec_q  <= wdata;
                if (hit && en_set)  en_q   <= 1'b1;
                if (hit && en_clr)  en_q   <= 1'b0;
                if ((hit && pend_clr) || (ack && ack_idx == IDX_W'(i)))
                    pstore_q <= 1'b0;
                else if ((hit && pend_set) || (mode_q[4] && active && !prev_q))
                    pstore_q <= 1'b1;
            end
        end

        assign mode_arr[i] = mode_q;
        assign vec_arr[i]  = vec_q;
        assign en_v[i]     = en_q;
        assign pend_v[i]   = pstore_q | (!mode_q[4] & active);
        assign req[i]      = en_q & pend_v[i];
        assign prio_flat[i*PRIO_W +: PRIO_W] = mode_q[PRIO_W-1:0];

        // R3: a disable command removes the source from arbitration
        assert_disable_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && en_clr && !en_set) |=> !req[i]);
    end

    logic sel_ok, ack_ok;
    assign sel_ok   = (int'(sel) < NUM_SRC);
    assign ack_ok   = (int'(ack_idx) < NUM_SRC);
    assign sel_mode = sel_ok ? mode_arr[sel] : '0;
    assign sel_vec  = sel_ok ? vec_arr[sel]  : '0;
    assign sel_en   = sel_ok ? en_v[sel]     : 1'b0;
    assign sel_pend = sel_ok ? pend_v[sel]   : 1'b0;
    assign ack_vec  = ack_ok ? vec_arr[ack_idx] : '0;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 128
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        // descending scan with >= lets the lower index win ties
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] >= win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/intc_nest_stack.sv
module intc_nest_stack
    import intc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic        pop,
    input  nest_entry_t push_entry,
    output nest_entry_t top,
    output logic        empty,
    output logic        full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    nest_state_t state_q, state_d;
    logic [CNT_W-1:0] depth_q;
    nest_entry_t      stk [DEPTH];
    logic             do_push, do_pop;

    assign do_push = push && (state_q != NS_FULL);
    assign do_pop  = pop && !push && (state_q != NS_EMPTY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NS_EMPTY:  if (do_push) state_d = (DEPTH == 1) ? NS_FULL : NS_NESTED;
            NS_NESTED: begin
                if (do_push && depth_q == CNT_W'(DEPTH - 1)) state_d = NS_FULL;
                else if (do_pop && depth_q == CNT_W'(1))     state_d = NS_EMPTY;
            end
            NS_FULL:   if (do_pop) state_d = (DEPTH == 1) ? NS_EMPTY : NS_NESTED;
            default:   state_d = NS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NS_EMPTY;
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else begin
            state_q <= state_d;
            if (do_push) begin
                stk[depth_q[CNT_W-1:0]] <= push_entry;
                depth_q <= depth_q + 1'b1;
            end else if (do_pop) begin
                depth_q <= depth_q - 1'b1;
            end
        end
    end

    always_comb begin
        empty = (state_q == NS_EMPTY);
        full  = (state_q == NS_FULL);
        top   = empty ? '0 : stk[depth_q - 1'b1];
    end

    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= CNT_W'(DEPTH));
    assert_push_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> depth_q == $past(depth_q) + 1'b1);
    assert_pop_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> depth_q == $past(depth_q) - 1'b1);
    assert_state_tracks_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (depth_q == '0)) && (full == (depth_q == CNT_W'(DEPTH))));
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 128,
    parameter int NEST_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_req
);
    logic [IDX_W-1:0]  sel_q;
    logic [31:0]       spur_q;
    logic [MODE_W-1:0] sel_mode;
    logic [31:0]       sel_vec, ack_vec;
    logic              sel_en, sel_pend;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic              found, take, vread;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;
    logic [LVL_W-1:0]  win_lvl, top_thresh;
    nest_entry_t       top, push_entry;
    logic              empty, full;

    logic wr_mode, wr_vec, wr_en, wr_dis, wr_clr, wr_set, wr_eoi;
    assign wr_mode = bus_wr && bus_addr == A_MODE;
    assign wr_vec  = bus_wr && bus_addr == A_VEC;
    assign wr_en   = bus_wr && bus_addr == A_EN;
    assign wr_dis  = bus_wr && bus_addr == A_DIS;
    assign wr_clr  = bus_wr && bus_addr == A_CLR;
    assign wr_set  = bus_wr && bus_addr == A_SET;
    assign wr_eoi  = bus_wr && bus_addr == A_EOI;
    assign vread   = bus_rd && bus_addr == A_VREAD;

    intc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .sel(sel_q),
        .mode_we(wr_mode), .vec_we(wr_vec), .wdata(bus_wdata),
        .en_set(wr_en), .en_clr(wr_dis), .pend_set(wr_set), .pend_clr(wr_clr),
        .ack(take), .ack_idx(win_idx),
        .sel_mode(sel_mode), .sel_vec(sel_vec), .sel_en(sel_en), .sel_pend(sel_pend),
        .ack_vec(ack_vec), .req(req), .prio_flat(prio_flat)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .req(req), .prio_flat(prio_flat),
        .found(found), .win_idx(win_idx), .win_prio(win_prio)
    );

    intc_nest_stack #(.DEPTH(NEST_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(vread), .pop(wr_eoi),
        .push_entry(push_entry), .top(top), .empty(empty), .full(full)
    );

    assign win_lvl    = {1'b0, win_prio} + 1'b1;
    assign top_thresh = top.thresh;
    assign irq_req    = found && (win_lvl > top_thresh);
    assign take       = vread && irq_req && !full;

    always_comb begin
        push_entry = '0;
        if (take) begin
            push_entry.real_src = 1'b1;
            push_entry.src      = win_idx;
            push_entry.thresh   = win_lvl;
        end else begin
            push_entry.thresh   = top_thresh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            spur_q    <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_wr && bus_addr == A_SEL)  sel_q  <= bus_wdata[IDX_W-1:0];
            if (bus_wr && bus_addr == A_SPUR) spur_q <= bus_wdata;
            if (bus_rd) begin
                unique case (bus_addr)
                    A_SEL:   bus_rdata <= 32'(sel_q);
                    A_MODE:  bus_rdata <= 32'(sel_mode);
                    A_VEC:   bus_rdata <= sel_vec;
                    A_VREAD: bus_rdata <= take ? ack_vec : spur_q;
                    A_CUR:   bus_rdata <= (top.real_src && !empty) ? 32'(top.src) : 32'd0;
                    A_STAT:  bus_rdata <= {30'd0, sel_pend, sel_en};
                    A_SPUR:  bus_rdata <= spur_q;
                    default: bus_rdata <= 32'd0;
                endcase
            end
        end
    end

    // R7: a vector read with nothing to acknowledge yields the spurious vector
    assert_spurious_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vread && !irq_req) |=> bus_rdata == $past(spur_q));
    // R6: an acknowledged read leaves its source on top of the stack
    assert_ack_on_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (top.real_src && top.src == $past(win_idx)));
    // R5: with no enabled pending source there is no request
    assert_no_req_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !irq_req);
endmodule

// File: tb/intc_vectored_bench.sv
module intc_vectored_bench;
    localparam int N = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_in = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_req;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    intc_vectored #(.NUM_SRC(N), .NEST_DEPTH(8)) u_intc_vectored (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    function automatic logic [31:0] vec_of(int i);
        return (i * 32'h0101_0107) ^ 32'h5A00_0000;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic setup(int s, logic [5:0] mode);
        wr(8'h00, 32'(s));
        wr(8'h04, 32'(mode));
        wr(8'h08, vec_of(s));
        wr(8'h40, 32'd1);
    endtask

    initial begin
        logic [31:0] d;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 irq", 32'(irq_req), 32'd0);
        rd(8'h00, d); chk("R10 sel", d, 32'd0);
        rd(8'h30, d); chk("R10 status", d, 32'd0);
        rd(8'h04, d); chk("R10 mode", d, 32'd0);
        rd(8'h08, d); chk("R10 vector", d, 32'd0);
        rd(8'h18, d); chk("R10 current", d, 32'd0);

        // R1: select width
        wr(8'h00, 32'hFFFF_FF85); rd(8'h00, d); chk("R1 select", d, 32'h05);

        // R2: sweep all sources for mode and vector storage
        for (int i = 0; i < N; i++) begin
            wr(8'h00, 32'(i));
            wr(8'h04, 32'((i * 5) & 6'h3F));
            wr(8'h08, vec_of(i));
        end
        for (int i = 0; i < N; i++) begin
            wr(8'h00, 32'(i));
            rd(8'h04, d); chk("R2 mode", d, 32'((i * 5) & 6'h3F));
            rd(8'h08, d); chk("R2 vector", d, vec_of(i));
            wr(8'h04, 32'd0);
            wr(8'h48, 32'd0);
        end

        // R3/R4: enable, set, clear, disable through status
        setup(40, 6'h00);
        rd(8'h30, d); chk("R3 enabled", d, 32'd1);
        chk("R3 irq idle", 32'(irq_req), 32'd0);
        wr(8'h4C, 32'd0);
        chk("R4 set irq", 32'(irq_req), 32'd1);
        rd(8'h30, d); chk("R4 set status", d, 32'd3);
        wr(8'h48, 32'd0);
        chk("R4 clear irq", 32'(irq_req), 32'd0);
        rd(8'h30, d); chk("R4 clear status", d, 32'd1);
        wr(8'h44, 32'd0);
        rd(8'h30, d); chk("R3 disabled", d, 32'd0);
        src_in[40] = 1'b1; @(negedge clk);
        chk("R3 disabled no irq", 32'(irq_req), 32'd0);
        src_in[40] = 1'b0;

        // R5/R6: priority, ties, strict nesting
        setup(2, 6'h01); setup(5, 6'h03); setup(9, 6'h03); setup(20, 6'h06);
        src_in[2] = 1'b1; src_in[5] = 1'b1; src_in[9] = 1'b1;
        @(negedge clk);
        chk("R5 irq", 32'(irq_req), 32'd1);
        rd(8'h10, d); chk("R5 tie lower index", d, vec_of(5));
        rd(8'h18, d); chk("R6 current", d, 32'd5);
        chk("R5 equal prio blocked", 32'(irq_req), 32'd0);
        src_in[20] = 1'b1; @(negedge clk);
        chk("R5 higher prio", 32'(irq_req), 32'd1);
        rd(8'h10, d); chk("R6 nested vector", d, vec_of(20));
        rd(8'h18, d); chk("R6 nested current", d, 32'd20);
        src_in[20] = 1'b0;
        wr(8'h38, 32'd0);
        chk("R8 pop keeps level", 32'(irq_req), 32'd0);
        rd(8'h18, d); chk("R8 pop current", d, 32'd5);
        wr(8'h38, 32'd0);
        chk("R8 empty irq", 32'(irq_req), 32'd1);
        src_in[2] = 1'b0; src_in[5] = 1'b0; src_in[9] = 1'b0;
        @(negedge clk);
        chk("R9 level follows", 32'(irq_req), 32'd0);

        // R9: edge latching
        setup(30, 6'h12);
        src_in[30] = 1'b1; @(negedge clk); src_in[30] = 1'b0; @(negedge clk);
        chk("R9 rising latched", 32'(irq_req), 32'd1);
        rd(8'h10, d); chk("R9 edge vector", d, vec_of(30));
        rd(8'h30, d); chk("R9 ack clears", d, 32'd1);
        wr(8'h38, 32'd0);
        chk("R9 after eoi", 32'(irq_req), 32'd0);
        src_in[31] = 1'b1;
        setup(31, 6'h34);
        chk("R9 falling idle", 32'(irq_req), 32'd0);
        src_in[31] = 1'b0; @(negedge clk); src_in[31] = 1'b1; @(negedge clk);
        chk("R9 falling latched", 32'(irq_req), 32'd1);
        rd(8'h10, d); chk("R9 falling vector", d, vec_of(31));
        wr(8'h38, 32'd0);
        src_in[31] = 1'b0; @(negedge clk); src_in[31] = 1'b1;
        wr(8'h48, 32'd0); wr(8'h44, 32'd0);

        // R7: spurious
        wr(8'h3C, 32'hDEAD_BEEF);
        rd(8'h10, d); chk("R7 spurious vector", d, 32'hDEAD_BEEF);
        rd(8'h18, d); chk("R7 current zero", d, 32'd0);
        setup(100, 6'h00); wr(8'h4C, 32'd0);
        chk("R7 level kept", 32'(irq_req), 32'd1);
        rd(8'h10, d); chk("R7 then real", d, vec_of(100));
        wr(8'h38, 32'd0); wr(8'h38, 32'd0);
        chk("R7 unwound", 32'(irq_req), 32'd0);
        wr(8'h44, 32'd0);

        // R8: eight nested levels
        for (int k = 0; k < 8; k++) begin
            setup(60 + k, 6'(k));
            wr(8'h4C, 32'd0);
            chk("R8 level irq", 32'(irq_req), 32'd1);
            rd(8'h10, d); chk("R8 level vector", d, vec_of(60 + k));
        end
        rd(8'h10, d); chk("R8 full spurious", d, 32'hDEAD_BEEF);
        for (int k = 7; k >= 0; k--) begin
            rd(8'h18, d); chk("R8 unwind current", d, 32'(60 + k));
            wr(8'h38, 32'd0);
        end
        rd(8'h18, d); chk("R8 empty current", d, 32'd0);
        wr(8'h00, 32'd60); wr(8'h4C, 32'd0);
        chk("R8 low prio after unwind", 32'(irq_req), 32'd1);
        rd(8'h10, d); chk("R8 low prio vector", d, vec_of(60));
        wr(8'h38, 32'd0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule